// File: doc/BRIEF.md
# Radix-4 SRT Iterative Divider

This block divides two unsigned fixed-point fractions with a radix-4 SRT recurrence. Both operands are W-bit words read with the binary point after the top bit, so a word `v` stands for `v / 2^(W-1)`. The divisor must be normalized, with its top bit set, which puts its value in [1, 2). The dividend may be any W-bit value. A one-cycle `start` pulse while the block is idle captures both operands. The block then runs W/2 iterations. Each iteration retires one signed quotient digit from {-2, -1, 0, +1, +2}, so it yields two quotient bits per cycle. A final cycle converts the redundant digits to binary and corrects a negative remainder.

Every iteration picks its digit from a coarse view of the work: a 7-bit two's-complement estimate of four times the partial remainder (4 integer bits, 3 fraction bits, truncated) and the top four divisor bits. It then subtracts the matching multiple of the divisor, which comes from shifts and a negation only. Because the digit set is redundant, the estimate can be rough. The partial remainder may go negative, but it never leaves ±2/3 of the divisor.

In integer terms the block returns the quotient `floor(dividend * 2^(W-2) / divisor)` and the matching non-negative remainder. Sign handling, exponents, normalization and rounding belong to surrounding logic.

Top module: `srt4_divider`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `done`, `quotient` and `remainder` are all 0. A reset during an operation abandons it, and no `done` follows.
- R2: `start` sampled high at a rising edge while `busy` is low captures `dividend` and `divisor`. `busy` is high from the next cycle until the cycle in which `done` rises.
- R3: `done` is high for exactly one cycle. It rises at the (W/2+1)-th rising edge after the edge that accepted `start`, and `busy` is low while `done` is high.
- R4: With a divisor whose top bit is 1, `quotient` equals `floor(dividend * 2^(W-2) / divisor)`.
- R5: `remainder` equals `dividend * 2^(W-2) - quotient * divisor` and lies in [0, divisor). A negative final partial remainder is corrected by adding the divisor and lowering the quotient by one.
- R6: Digit choice follows four thresholds on the 7-bit estimate e (unit 1/8) for divisor top nibble t (8..15, unit 1/8). The digit is +2 when e >= ceil(4(t+1)/3), +1 when e >= ceil((t+1)/3), 0 when e >= -ceil((t+1)/3), -1 when e >= -ceil(4(t+1)/3), and -2 otherwise. After every iteration the partial remainder stays within ±2/3 of the divisor.
- R7: `start` while `busy` is high is ignored. The running operation finishes on time with the result for its own operands.
- R8: `quotient` and `remainder` hold their last result until the next operation completes, whatever happens on `dividend` and `divisor`.
- R9: A zero dividend gives quotient 0 and remainder 0. A dividend equal to the divisor gives quotient 2^(W-2) and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | W | Unsigned dividend, binary point after the top bit |
| divisor | input | W | Normalized divisor, top bit must be 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Binary quotient |
| remainder | output | W | Non-negative final remainder |

## Verification
The hardest conditions to reach from the ports lie in the middle of the digit loop. One is a shifted remainder that lands just beside one of the selection thresholds of a given divisor band. Another is a sequence of digits that leaves the final partial remainder negative, so that the correction cycle has to act. Neither is visible at the outputs. The stimulus therefore combines two sources: directed operands at the ratio extremes (largest dividend over smallest divisor, equal operands, tiny dividends over the largest divisor), and several hundred pseudo-random operand pairs spread over all eight divisor bands. Every result is checked against an integer reference, and a bound property inspects the partial remainder after every iteration.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

    // width of the shifted remainder estimate: 4 integer + 3 fraction bits
    localparam int EST_W  = 7;
    // width of the truncated divisor (1.xxx)
    localparam int DIVT_W = 4;

    // signed quotient digit, legal values -2..+2
    typedef logic signed [2:0] qdig_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } srt_state_e;

    // threshold between digit 0 and +1, in eighths: ceil((t+1)/3)
    function automatic int lo_cut(input int t);
        return (t + 3) / 3;
    endfunction

    // threshold between digit +1 and +2, in eighths: ceil(4(t+1)/3)
    function automatic int hi_cut(input int t);
        return (4 * t + 6) / 3;
    endfunction

endpackage

// File: rtl/srt4_digit_sel.sv
module srt4_digit_sel
    import srt4_pkg::*;
(
    input  logic signed [EST_W-1:0]  est,
    input  logic        [DIVT_W-2:0] dfrac,
    output qdig_t                    dig
);

    localparam int NBANDS = 1 << (DIVT_W - 1);

    qdig_t band_dig [NBANDS];

    // one comparator bank per divisor interval 1.000 .. 1.111
    for (genvar i = 0; i < NBANDS; i++) begin : g_band
        localparam int TOP = NBANDS + i;
        localparam int LO  = lo_cut(TOP);
        localparam int HI  = hi_cut(TOP);
        localparam logic signed [EST_W-1:0] P_HI = EST_W'(HI);
        localparam logic signed [EST_W-1:0] P_LO = EST_W'(LO);
        localparam logic signed [EST_W-1:0] N_LO = EST_W'(-LO);
        localparam logic signed [EST_W-1:0] N_HI = EST_W'(-HI);

        assign band_dig[i] = (est >= P_HI) ?  3'sd2 :
                             (est >= P_LO) ?  3'sd1 :
                             (est >= N_LO) ?  3'sd0 :
                             (est >= N_HI) ? -3'sd1 :
                                             -3'sd2;
    end

    assign dig = band_dig[dfrac];

endmodule

// File: rtl/srt4_mult_gen.sv
module srt4_mult_gen
    import srt4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic        [W-1:0]   dv,
    input  qdig_t                 dig,
    output logic signed [W+5:0]   mult
);

    localparam int RW = W + 6;

    // divisor aligned to the remainder scale (two extra fraction bits)
    logic signed [RW-1:0] base;
    logic signed [RW-1:0] cand [5];

    assign base = {4'b0000, dv, 2'b00};

    // candidate multiples for digits -2..+2: shifts and negation only
    for (genvar k = 0; k < 5; k++) begin : g_mul
        localparam int DV = k - 2;
        if (DV == 0) begin : g_zero
            assign cand[k] = '0;
        end else if (DV > 0) begin : g_pos
            assign cand[k] = base <<< (DV - 1);
        end else begin : g_neg
            assign cand[k] = -(base <<< (-DV - 1));
        end
    end

    always_comb begin
        case (dig)
            3'sd2:   mult = cand[4];
            3'sd1:   mult = cand[3];
            -3'sd1:  mult = cand[1];
            -3'sd2:  mult = cand[0];
            default: mult = cand[2];
        endcase
    end

endmodule

// File: rtl/srt4_qacc.sv
module srt4_qacc
    import srt4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  qdig_t        dig,
    output logic [W-1:0] qpos,
    output logic [W-1:0] qneg
);

    logic [1:0] pbits;
    logic [1:0] nbits;

    always_comb begin
        pbits = 2'd0;
        nbits = 2'd0;
        case (dig)
            3'sd1:  pbits = 2'd1;
            3'sd2:  pbits = 2'd2;
            -3'sd1: nbits = 2'd1;
            -3'sd2: nbits = 2'd2;
            default: ;
        endcase
    end

    // positive and negative digit weights kept apart: no carry per step
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            qpos <= '0;
            qneg <= '0;
        end else if (step) begin
            qpos <= {qpos[W-3:0], pbits};
            qneg <= {qneg[W-3:0], nbits};
        end
    end

endmodule

// File: rtl/srt4_ctrl.sv
module srt4_ctrl
    import srt4_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic fin,
    output logic busy
);

    localparam int CW = $clog2(STEPS) + 1;

    srt_state_e    st;
    logic [CW-1:0] cnt;

    assign load = start && (st == ST_IDLE);
    assign step = (st == ST_RUN);
    assign fin  = (st == ST_FIX);
    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(STEPS - 1)) st <= ST_FIX;
                end
                ST_FIX:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
    import srt4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    localparam int STEPS = W / 2;
    localparam int RW    = W + 6;

    typedef struct packed {
        logic [W-1:0] quo;
        logic [W-1:0] rem;
    } result_t;

    logic                 load;
    logic                 step;
    logic                 fin;
    logic signed [RW-1:0] rem_q;
    logic        [W-1:0]  div_q;
    logic signed [RW-1:0] rem_sh;
    logic signed [RW-1:0] mult;
    logic signed [RW-1:0] rem_next;
    logic signed [EST_W-1:0] est;
    qdig_t                dig;
    logic        [W-1:0]  qpos;
    logic        [W-1:0]  qneg;
    logic                 rem_neg;
    result_t              res_next;
    result_t              res_q;

    srt4_ctrl #(.STEPS(STEPS)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .fin   (fin),
        .busy  (busy)
    );

    // shifted remainder and its 7-bit estimate (4 int, 3 frac)
    assign rem_sh = rem_q <<< 2;
    assign est    = rem_q[W+2:W-4];

    srt4_digit_sel sel_i (
        .est   (est),
        .dfrac (div_q[W-2:W-4]),
        .dig   (dig)
    );

    srt4_mult_gen #(.W(W)) mul_i (
        .dv   (div_q),
        .dig  (dig),
        .mult (mult)
    );

    srt4_qacc #(.W(W)) qacc_i (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (step),
        .dig   (dig),
        .qpos  (qpos),
        .qneg  (qneg)
    );

    assign rem_next = rem_sh - mult;

    // final conversion: binary quotient and non-negative remainder
    assign rem_neg = rem_q[RW-1];
    always_comb begin
        res_next.rem = rem_q[W+1:2] + (rem_neg ? div_q : '0);
        res_next.quo = qpos - qneg - W'(rem_neg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            div_q <= '0;
            res_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= fin;
            if (load) begin
                rem_q <= RW'(dividend);
                div_q <= divisor;
            end else if (step) begin
                rem_q <= rem_next;
            end
            if (fin) res_q <= res_next;
        end
    end

    assign quotient  = res_q.quo;
    assign remainder = res_q.rem;

endmodule

// File: rtl/srt4_divider_chk.sv
module srt4_divider_chk #(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [W-1:0]      quotient,
    input logic [W-1:0]      remainder,
    input logic [W-1:0]      div_q,
    input logic signed [W+5:0] rem_q
);

    localparam int STEPS = W / 2;
    localparam int RW    = W + 6;
    localparam int CW    = $clog2(STEPS + 3) + 1;

    logic [CW-1:0] since_go;
    logic [RW+1:0] mag;
    logic [RW+1:0] mag3;
    logic [RW+1:0] lim8;

    // cycles elapsed since the accepted start
    always_ff @(posedge clk) begin
        if (rst)                since_go <= '0;
        else if (start && !busy) since_go <= CW'(1);
        else if (busy)          since_go <= since_go + 1'b1;
    end

    // remainder is scaled by 4 relative to the divisor word
    always_comb begin
        mag  = rem_q[RW-1] ? (RW+2)'(-rem_q) : (RW+2)'(rem_q);
        mag3 = mag + (mag << 1);
        lim8 = (RW+2)'({div_q, 3'b000});
    end

    a_r6_rem_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mag3 <= lim8));

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_go == CW'(STEPS + 2)));

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_rem_below_div: assert property (@(posedge clk) disable iff (rst)
        done |-> (remainder < div_q));

    a_r7_ignore_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(div_q));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(quotient) && $stable(remainder)));

endmodule

bind srt4_divider srt4_divider_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_q     (div_q),
    .rem_q     (rem_q)
);

// File: tb/srt4_divider_tb_top.sv
`timescale 1ns/1ps
module srt4_divider_tb_top;

    localparam int W     = 16;
    localparam int STEPS = W / 2;
    localparam int LAT   = STEPS + 1;
    localparam int NVEC  = 12;

    // stimulus table {dividend, divisor}; expected values come from ref_div
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {16'h0000, 16'h8000}, {16'h8000, 16'h8000}, {16'hFFFF, 16'h8000},
        {16'hFFFF, 16'hFFFF}, {16'h0001, 16'hFFFF}, {16'h7FFF, 16'h8001},
        {16'hC000, 16'hC000}, {16'h1234, 16'h9ABC}, {16'hFFFE, 16'h8000},
        {16'h5555, 16'hAAAA}, {16'hAAAA, 16'hBFFF}, {16'h0003, 16'h8000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = 16'h8000;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [31:0]  rng = 32'h1F2E3D4C;

    always #4 clk = ~clk;

    srt4_divider #(.W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [W-1:0] x, input logic [W-1:0] d,
                                    output longint q, output longint r);
        longint num;
        num = longint'(x) << (W - 2);
        q   = num / longint'(d);
        r   = num - q * longint'(d);
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // one division; optionally pulses start with other operands mid-run (R7)
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] d,
                          input bit poke, input string tag);
        int     lat;
        longint eq, er;
        ref_div(x, d, eq, er);
        @(negedge clk);
        dividend = x;
        divisor  = d;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        check({tag, " R2 busy after start"}, 64'(busy), 64'd1);
        while (!done && lat < 40) begin
            if (poke && lat == 2) begin
                start    = 1'b1;
                dividend = ~x;
                divisor  = {1'b1, ~d[W-2:0]};
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check({tag, " R3 latency"}, 64'(lat), 64'(LAT));
        check({tag, " R3 busy low at done"}, 64'(busy), 64'd0);
        check({tag, " R4/R6 quotient"}, 64'(quotient), 64'(eq));
        check({tag, " R5 remainder"}, 64'(remainder), 64'(er));
        @(negedge clk);
        check({tag, " R3 done pulse width"}, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 busy in reset", 64'(busy), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 quotient in reset", 64'(quotient), 64'd0);
        check("R1 remainder in reset", 64'(remainder), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 64'(busy), 64'd0);

        // table walk; first entries double as R9 corners
        for (int i = 0; i < NVEC; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] d;
            x = VEC[i][2*W-1:W];
            d = VEC[i][W-1:0];
            run_op(x, d, 1'b0, $sformatf("vec%0d", i));
            if (i == 0) begin
                check("R9 zero dividend quotient", 64'(quotient), 64'd0);
                check("R9 zero dividend remainder", 64'(remainder), 64'd0);
            end
            if (i == 1) begin
                check("R9 equal operands quotient", 64'(quotient), 64'(1 << (W - 2)));
                check("R9 equal operands remainder", 64'(remainder), 64'd0);
            end
        end

        // R8: outputs hold while inputs wander without start
        begin
            logic [W-1:0] hq;
            logic [W-1:0] hr;
            hq = quotient;
            hr = remainder;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                dividend = dividend + 16'h1357;
                divisor  = {1'b1, divisor[W-2:0] ^ 15'h2A5A};
            end
            check("R8 quotient held", 64'(quotient), 64'(hq));
            check("R8 remainder held", 64'(remainder), 64'(hr));
            check("R8 no spurious done", 64'(done), 64'd0);
        end

        // R7: start during busy is ignored
        run_op(16'hBEEF, 16'h9001, 1'b1, "R7 poke a");
        run_op(16'h0042, 16'hF00D, 1'b1, "R7 poke b");

        // R1: reset during an operation abandons it
        @(negedge clk);
        dividend = 16'hABCD;
        divisor  = 16'hC321;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 busy after mid reset", 64'(busy), 64'd0);
        check("R1 quotient after mid reset", 64'(quotient), 64'd0);
        check("R1 remainder after mid reset", 64'(remainder), 64'd0);
        rst = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < LAT + 4; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R1 no done after abandoned op", 64'(seen), 64'd0);
        end

        // pseudo-random normalized operands, all divisor bands (R4, R5, R6)
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x;
            logic [W-1:0] d;
            rng = next_rng(rng);
            x   = rng[W-1:0];
            d   = {1'b1, rng[2*W-2:W]};
            run_op(x, d, 1'b0, $sformatf("rand%0d", n));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule